// File: doc/BRIEF.md
# Single-Bus Register Datapath Step Engine

This block runs a register datapath built around one shared bus. It takes a stream of 16-bit control words on a valid/ready input and executes one word per accepted transfer. In each step, exactly one source register places its value on the bus. Any set of destination registers then captures that value in the same clock edge. Two destinations go through small adders: `w` stores the bus value plus one, and `z` stores the bus value plus the current `y`. The register file holds `w`, `y`, `z` and five general registers `r1`..`r5`. A sixth source, `r0`, always reads as zero and cannot be written. The data width is the parameter `WIDTH`.

The block shows every register value and a step counter at all times. It pulses `out_valid` once for each executed word. A word whose drive field does not select exactly one source is a bus fault, and the block halts with `error`. The all-zero word ends the program, and the block halts with `done`. While halted, the block drops `in_ready` and stays frozen until a synchronous reset.

The controller has three states:
- `ST_RUN` accepts words. `ST_RUN -> ST_DONE` is taken on an accepted all-zero word. `ST_RUN -> ST_FAULT` is taken on an accepted non-zero word whose drive field is not one-hot. Every other accepted word stays in `ST_RUN` and executes.
- `ST_DONE` and `ST_FAULT` hold until `rst`, which returns the controller to `ST_RUN`.

Top module: `bus_step_engine`

## Requirements
- R1: After a synchronous reset, the following hold: all registers and `step_cnt` are zero, `done`, `error` and `out_valid` are low, and `in_ready` is high.
- R2: Loading `w` stores bus+1, and loading `z` stores bus+`y`, both wrapping modulo 2^WIDTH. Loading `y` or `r1`..`r5` stores the bus value unchanged.
- R3: The load field is in bits 15..8: bit 15 `w`, 14 `y`, 13 `z`, 12 `r1`, 11 `r2`, 10 `r3`, 9 `r4`, 8 `r5`. The drive field is in bits 7..0: bit 7 `w`, 6 `r0`, 5 `z`, 4 `r1`, 3 `r2`, 2 `r3`, 1 `r4`, 0 `r5`.
- R4: A non-zero word whose drive field has zero or more than one bit set raises `error`. It changes no register and no step count, and moves the controller to `ST_FAULT`.
- R5: The word 0x0000 raises `done`, changes no register, produces no `out_valid`, and moves the controller to `ST_DONE`.
- R6: A register that both drives and loads in one step uses its value from before the step. For example, 0x8080 gives `w` = old `w` + 1, and 0x2020 gives `z` = old `z` + `y`.
- R7: While in `ST_DONE` or `ST_FAULT`, `in_ready` is low, input words are ignored, and all outputs hold until reset.
- R8: Each executed word raises `out_valid` for one cycle after the accepting edge, with `step_cnt` advanced by one (wrapping).
- R9: Driving from `r0` puts zero on the bus.
- R10: With `in_valid` low, no register, counter or status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Control word offered |
| in_ready | output | 1 | Block can accept a word (high only in ST_RUN) |
| in_word | input | 16 | Control word: load field [15:8], drive field [7:0] |
| out_valid | output | 1 | One-cycle pulse after each executed word |
| step_cnt | output | CNT_W | Number of executed words, wrapping |
| w_q | output | WIDTH | Register w |
| y_q | output | WIDTH | Register y |
| z_q | output | WIDTH | Register z |
| gp_q | output | 5*WIDTH | r1..r5; rk at bits [(k-1)*WIDTH +: WIDTH] |
| done | output | 1 | Halted on the terminating word |
| error | output | 1 | Halted on a bus fault |

## Verification
Every effect of a word appears one cycle after the rising edge that accepts it. That includes the register values, `step_cnt`, the `out_valid` pulse, and the `done` or `error` flag. The driver presents each word just after a falling edge and removes it at the next falling edge. It pushes the predicted register image into a scoreboard queue, and a monitor pops and compares that image at the falling edge where `out_valid` is high. Halting words push nothing. The flags and the frozen register image are checked at the falling edge that follows the accepting edge, and checked again on later words that are offered while `in_ready` is low.

// File: rtl/bse_pkg.sv
package bse_pkg;

    localparam int NGP    = 5;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DONE,
        ST_FAULT
    } bse_state_e;

    typedef struct packed {
        logic           ld_w;
        logic           ld_y;
        logic           ld_z;
        logic [NGP-1:0] ld_gp;
        logic           dr_w;
        logic           dr_r0;
        logic           dr_z;
        logic [NGP-1:0] dr_gp;
    } bse_ctl_t;

endpackage

// File: rtl/bse_decode.sv
module bse_decode
    import bse_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output bse_ctl_t          ctl,
    output logic              is_end,
    output logic              bus_ok
);

    assign ctl.ld_w  = word[15];
    assign ctl.ld_y  = word[14];
    assign ctl.ld_z  = word[13];
    assign ctl.dr_w  = word[7];
    assign ctl.dr_r0 = word[6];
    assign ctl.dr_z  = word[5];

    for (genvar k = 0; k < NGP; k++) begin : g_gp_bits
        assign ctl.ld_gp[k] = word[12-k];
        assign ctl.dr_gp[k] = word[4-k];
    end

    assign is_end = (word == '0);
    assign bus_ok = ($countones(word[7:0]) == 1);

endmodule

// File: rtl/bse_fsm.sv
module bse_fsm
    import bse_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             is_end,
    input  logic             bus_ok,
    output logic             in_ready,
    output logic             exec,
    output logic             out_valid,
    output logic [CNT_W-1:0] step_cnt,
    output logic             done,
    output logic             error
);

    bse_state_e state, nxt;
    logic       accept;

    assign accept = in_valid && (state == ST_RUN);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (accept && is_end) begin
                    nxt = ST_DONE;
                end else if (accept && !bus_ok) begin
                    nxt = ST_FAULT;
                end
            end
            ST_DONE:  nxt = ST_DONE;
            ST_FAULT: nxt = ST_FAULT;
            default:  nxt = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        in_ready = (state == ST_RUN);
        exec     = accept && !is_end && bus_ok;
        done     = (state == ST_DONE);
        error    = (state == ST_FAULT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            step_cnt  <= '0;
        end else begin
            out_valid <= exec;
            if (exec) begin
                step_cnt <= step_cnt + CNT_W'(1);
            end
        end
    end

    p_fault_on_bad_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !is_end && !bus_ok) |=> error);

    p_end_sets_done_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && is_end) |=> (done && !out_valid));

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (done || error) |=> ($stable(done) && $stable(error) && !in_ready));

    p_step_inc_r8: assert property (@(posedge clk) disable iff (rst)
        exec |=> (out_valid && step_cnt == $past(step_cnt) + CNT_W'(1)));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(step_cnt) && !out_valid));

endmodule

// File: rtl/bse_regfile.sv
module bse_regfile
    import bse_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec,
    input  bse_ctl_t         ctl,
    output logic [WIDTH-1:0] w_q,
    output logic [WIDTH-1:0] y_q,
    output logic [WIDTH-1:0] z_q,
    output logic [WIDTH-1:0] gp_q [NGP]
);

    localparam logic [WIDTH-1:0] R0_VAL = '0;

    logic [WIDTH-1:0] bus;
    logic [WIDTH-1:0] w_sum;
    logic [WIDTH-1:0] z_sum;

    always_comb begin
        bus = '0;
        if (ctl.dr_w)  bus = bus | w_q;
        if (ctl.dr_r0) bus = bus | R0_VAL;
        if (ctl.dr_z)  bus = bus | z_q;
        for (int k = 0; k < NGP; k++) begin
            if (ctl.dr_gp[k]) bus = bus | gp_q[k];
        end
    end

    assign w_sum = bus + WIDTH'(1);
    assign z_sum = bus + y_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (exec) begin
            if (ctl.ld_w) w_q <= w_sum;
            if (ctl.ld_y) y_q <= bus;
            if (ctl.ld_z) z_q <= z_sum;
        end
    end

    for (genvar k = 0; k < NGP; k++) begin : g_gp
        always_ff @(posedge clk) begin
            if (rst) begin
                gp_q[k] <= '0;
            end else if (exec && ctl.ld_gp[k]) begin
                gp_q[k] <= bus;
            end
        end
    end

    p_w_self_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (exec && ctl.ld_w && ctl.dr_w) |=> (w_q == $past(w_q) + WIDTH'(1)));

    p_z_adds_y_r2: assert property (@(posedge clk) disable iff (rst)
        (exec && ctl.ld_z) |=> (z_q == $past(bus) + $past(y_q)));

    p_r1_plain_load_r2: assert property (@(posedge clk) disable iff (rst)
        (exec && ctl.ld_gp[0]) |=> (gp_q[0] == $past(bus)));

    p_r0_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (exec && ctl.dr_r0 && ctl.ld_y) |=> (y_q == '0));

endmodule

// File: rtl/bus_step_engine.sv
module bus_step_engine
    import bse_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [15:0]          in_word,
    output logic                 out_valid,
    output logic [CNT_W-1:0]     step_cnt,
    output logic [WIDTH-1:0]     w_q,
    output logic [WIDTH-1:0]     y_q,
    output logic [WIDTH-1:0]     z_q,
    output logic [5*WIDTH-1:0]   gp_q,
    output logic                 done,
    output logic                 error
);

    bse_ctl_t         ctl;
    logic             is_end;
    logic             bus_ok;
    logic             exec;
    logic [WIDTH-1:0] gp_arr [NGP];

    bse_decode u_decode (
        .word   (in_word),
        .ctl    (ctl),
        .is_end (is_end),
        .bus_ok (bus_ok)
    );

    bse_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .is_end    (is_end),
        .bus_ok    (bus_ok),
        .in_ready  (in_ready),
        .exec      (exec),
        .out_valid (out_valid),
        .step_cnt  (step_cnt),
        .done      (done),
        .error     (error)
    );

    bse_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .exec (exec),
        .ctl  (ctl),
        .w_q  (w_q),
        .y_q  (y_q),
        .z_q  (z_q),
        .gp_q (gp_arr)
    );

    for (genvar k = 0; k < NGP; k++) begin : g_flat
        assign gp_q[k*WIDTH +: WIDTH] = gp_arr[k];
    end

    p_frozen_when_halted_r7: assert property (@(posedge clk) disable iff (rst)
        (done || error) |=> ($stable(w_q) && $stable(y_q) && $stable(z_q)
                             && $stable(gp_q) && $stable(step_cnt)));

    p_fault_no_change_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !is_end && !bus_ok) |=> ($stable(w_q) && $stable(gp_q)));

    p_status_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

endmodule

// File: tb/tb_bus_step_engine.sv
`timescale 1ns/1ps
module tb_bus_step_engine;

    localparam int W  = 8;
    localparam int CW = 8;

    typedef struct packed {
        logic [CW-1:0]  step;
        logic [W-1:0]   w;
        logic [W-1:0]   y;
        logic [W-1:0]   z;
        logic [5*W-1:0] gp;
    } img_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [15:0]    in_word = '0;
    logic           in_ready, out_valid, done, error;
    logic [CW-1:0]  step_cnt;
    logic [W-1:0]   w_q, y_q, z_q;
    logic [5*W-1:0] gp_q;

    int checks = 0;
    int errors = 0;

    img_t exp_q [$];

    logic [W-1:0]  m_w, m_y, m_z;
    logic [W-1:0]  m_gp [5];
    logic [CW-1:0] m_step;
    logic          m_halt;

    always #4 clk = ~clk;

    bus_step_engine #(.WIDTH(W), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .step_cnt(step_cnt),
        .w_q(w_q), .y_q(y_q), .z_q(z_q), .gp_q(gp_q),
        .done(done), .error(error)
    );

    function automatic img_t model_img();
        img_t t;
        t.step = m_step;
        t.w = m_w;
        t.y = m_y;
        t.z = m_z;
        for (int k = 0; k < 5; k++) t.gp[k*W +: W] = m_gp[k];
        return t;
    endfunction

    function automatic img_t dut_img();
        img_t t;
        t.step = step_cnt;
        t.w = w_q;
        t.y = y_q;
        t.z = z_q;
        t.gp = gp_q;
        return t;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected out_valid", 64'(dut_img()), 64'd0);
            end else begin
                img_t e;
                e = exp_q.pop_front();
                chk(dut_img() == e, "R2/R3/R8 step image", 64'(dut_img()), 64'(e));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_w = '0; m_y = '0; m_z = '0; m_step = '0; m_halt = 1'b0;
        for (int k = 0; k < 5; k++) m_gp[k] = '0;
    endtask

    task automatic send(input logic [15:0] wd);
        logic [W-1:0] bus, ow, oy, oz;
        logic [W-1:0] ogp [5];
        @(negedge clk);
        in_valid = 1'b1;
        in_word = wd;
        if (m_halt) begin
            chk(in_ready == 1'b0, "R7 in_ready low when halted", 64'(in_ready), 64'd0);
        end else if (wd == 16'h0000) begin
            m_halt = 1'b1;
        end else if ($countones(wd[7:0]) != 1) begin
            m_halt = 1'b1;
        end else begin
            ow = m_w; oy = m_y; oz = m_z;
            for (int k = 0; k < 5; k++) ogp[k] = m_gp[k];
            bus = '0;
            if (wd[7]) bus = ow;
            if (wd[6]) bus = '0;
            if (wd[5]) bus = oz;
            for (int k = 0; k < 5; k++) if (wd[4-k]) bus = ogp[k];
            if (wd[15]) m_w = bus + W'(1);
            if (wd[14]) m_y = bus;
            if (wd[13]) m_z = bus + oy;
            for (int k = 0; k < 5; k++) if (wd[12-k]) m_gp[k] = bus;
            m_step = m_step + CW'(1);
            exp_q.push_back(model_img());
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_image(input string req);
        chk(dut_img() == model_img(), req, 64'(dut_img()), 64'(model_img()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(dut_img() == '0, "R1 registers zero", 64'(dut_img()), 64'd0);
        chk({done, error, out_valid, in_ready} == 4'b0001, "R1 status",
            64'({done, error, out_valid, in_ready}), 64'd1);

        // R2 R3 R9 program from arithmetic examples
        send(16'h8040); send(16'h1080); send(16'h0840); send(16'h4010);
        send(16'h2010); send(16'h0820); send(16'h8040); send(16'h8080);
        send(16'h8080); send(16'h0480);
        chk(gp_q[2*W +: W] == W'(3), "R3 r3 after program", 64'(gp_q[2*W +: W]), 64'd3);
        chk(z_q == W'(2), "R2 z=r1+y", 64'(z_q), 64'd2);

        // R6 same register drive and load
        send(16'h2020);
        chk(z_q == W'(3), "R6 z<-z+y", 64'(z_q), 64'd3);
        // R3 r5/r4 fields, R9 r0 clears y
        send(16'h0180); send(16'h0201); send(16'h4040);
        chk(y_q == '0, "R9 r0 drives zero", 64'(y_q), 64'd0);

        // R2 wrap of w and step counter
        for (int i = 0; i < 260; i++) send(16'h8080);
        chk(w_q == W'(3 + 260), "R2 w wraps", 64'(w_q), 64'(W'(3 + 260)));

        // R10 idle cycles change nothing
        repeat (5) begin
            @(negedge clk);
            chk(!out_valid, "R10 no out_valid when idle", 64'(out_valid), 64'd0);
        end
        chk_image("R10 image held when idle");

        // R4 two drivers
        send(16'h8003);
        chk(error && !done, "R4 error on two drivers", 64'({error, done}), 64'd2);
        chk_image("R4 no change on fault");
        // R7 ignored while halted
        send(16'h8040);
        @(negedge clk);
        chk_image("R7 image frozen after fault");
        chk(error, "R7 error sticky", 64'(error), 64'd1);

        // R4 zero driver
        do_reset();
        @(negedge clk);
        chk(dut_img() == '0 && in_ready && !error, "R1 reset clears fault",
            64'(dut_img()), 64'd0);
        send(16'h1000);
        chk(error, "R4 error on no driver", 64'(error), 64'd1);
        chk_image("R4 no change, no driver");

        // R5 terminating word
        do_reset();
        send(16'h8040);
        send(16'h0000);
        chk(done && !error && !out_valid, "R5 done on end word",
            64'({done, error, out_valid}), 64'd4);
        chk_image("R5 no change on end word");
        send(16'h4080);
        @(negedge clk);
        chk_image("R7 frozen after done");
        chk(!in_ready, "R7 in_ready low after done", 64'(in_ready), 64'd0);

        chk(exp_q.size() == 0, "R8 all steps reported", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule